// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind the serial protocol engine of a small byte-addressed nonvolatile memory. When the engine has decoded a write command and its word address, it pulses `cmd_start` with that address. Each data byte that completes with an acknowledge arrives as a one-cycle `byte_valid` strobe. The block parks each byte in a 16-slot page buffer. The upper address bits stay fixed while the low four bits advance and wrap inside the page. If more bytes arrive than the page holds, later bytes overwrite earlier slots.

When the engine sees a STOP after a complete byte, it pulses `commit_req`. If at least one byte was collected and the write-protect input does not cover the page, the block enters a self-timed busy interval of `BUSY_CYCLES` clock cycles. Early in that interval it streams every collected slot, and only those, to the array write port in ascending slot order. Protection is judged once, at commit. While busy, the block ignores every command input. The final address counter value is always available on `addr_cnt`.

Top module: `page_write_buffer`

## Requirements
- R1: After synchronous reset, `busy` and `arr_we` are low and `addr_cnt` is 0.
- R2: The k-th byte of a command (k from 0) is written at address {upper bits of the command address, (low four bits + k) mod 16}; the upper five bits never change within a command.
- R3: When more than 16 bytes arrive in one command, each slot holds the last byte sent to it, so only the final 16 bytes are written.
- R4: Only slots that received a byte in the current command are written. Each is written exactly once, in ascending slot order, and `arr_we` is high only while `busy` is high.
- R5: A `commit_req` after at least one byte raises `busy` on the next cycle and holds it for exactly `BUSY_CYCLES` cycles.
- R6: A command with no data bytes (an address-only write) commits nothing, leaves `busy` low and leaves `addr_cnt` at the command address.
- R7: With `wp` high at commit, a page whose address bit 8 is 1 (0x100–0x1FF) is neither written nor made busy. Pages with bit 8 at 0 are written regardless of `wp`, and any page is written when `wp` is low.
- R8: Raising `wp` after `busy` has risen does not stop or shorten the write.
- R9: While `busy` is high, `cmd_start`, `byte_valid` and `commit_req` are ignored: `addr_cnt` does not change, and no extra write or busy interval follows.
- R10: After a write, `addr_cnt` holds the address following the last byte received, wrapped inside the page. A command that ends on slot 15 leaves it on slot 0 of the same page.
- R11: A new `cmd_start` before `commit_req` discards the bytes already collected for the earlier command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Write command with word address decoded |
| cmd_addr | input | 9 | Word address of the command |
| byte_valid | input | 1 | One acknowledged data byte is present |
| byte_data | input | 8 | Data byte |
| commit_req | input | 1 | STOP seen after a complete byte |
| wp | input | 1 | Write protect for the upper half of the array |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 9 | Array write address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Self-timed write interval in progress |
| addr_cnt | output | 9 | Current address counter |

## Verification
The scoreboard predicts the exact sequence of array writes from a slot model. It therefore catches a design that writes slots never received, that loses the wrap from slot 15 to slot 0, or that keeps the first 16 bytes of an overlong burst instead of the last. Protection is checked with `wp` high on both halves and raised mid-write; a wrong design would block lower-half writes, leak upper-half writes, or abort a started write. The bench also injects a full set of command strobes during busy, where a design that does not lock them out would move the address counter or start a second write. Address-only writes and restarted commands check that busy and the counter follow only the bytes that count.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        PWB_IDLE  = 2'd0,
        PWB_FILL  = 2'd1,
        PWB_WRITE = 2'd2
    } pwb_state_t;

    // busy interval never shorter than one scan over the buffer
    function automatic int unsigned pwb_hold_len(input int unsigned busy_cycles,
                                                 input int unsigned slots);
        return (busy_cycles < slots) ? slots : busy_cycles;
    endfunction

endpackage

// File: rtl/pwb_addr_track.sv
module pwb_addr_track #(
    parameter int ADDR_W = 9,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int HI_W = ADDR_W - IDX_W;

    logic [HI_W-1:0]  hi_q;
    logic [IDX_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (load) begin
            hi_q <= load_addr[ADDR_W-1:IDX_W];
            lo_q <= load_addr[IDX_W-1:0];
        end else if (step) begin
            lo_q <= lo_q + 1'b1;
        end
    end

    assign addr_q = {hi_q, lo_q};

    AST_STEP_KEEPS_PAGE: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> $stable(addr_q[ADDR_W-1:IDX_W])); // R2

endmodule

// File: rtl/pwb_slot_store.sv
module pwb_slot_store #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    localparam int SLOTS = 1 << IDX_W;

    logic [DATA_W-1:0] data_arr [SLOTS];
    logic [SLOTS-1:0]  valid_vec;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [DATA_W-1:0] d_q;
        logic              v_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(s))) begin
                v_q <= 1'b1;
                d_q <= wr_data;
            end
        end
        assign data_arr[s]  = d_q;
        assign valid_vec[s] = v_q;
    end

    assign rd_data   = data_arr[rd_idx];
    assign rd_valid  = valid_vec[rd_idx];
    assign any_valid = |valid_vec;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (clr && !wr_en) |=> !any_valid); // R11

endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq
    import pwb_pkg::*;
#(
    parameter int IDX_W       = 4,
    parameter int BUSY_CYCLES = 2_500_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start,
    input  logic             byte_valid,
    input  logic             commit_req,
    input  logic             wp,
    input  logic             page_upper,
    input  logic             any_valid,
    output logic             load,
    output logic             step,
    output logic             busy,
    output logic             scan_active,
    output logic [IDX_W-1:0] scan_idx
);
    localparam int SLOTS = 1 << IDX_W;
    localparam int HOLD  = int'(pwb_hold_len(BUSY_CYCLES, SLOTS));
    localparam int CNT_W = $clog2(HOLD + 1);

    pwb_state_t       state_q;
    logic [CNT_W-1:0] tmr_q;
    logic             commit_ok;
    logic             commit_now;

    assign load       = cmd_start && (state_q != PWB_WRITE);
    assign step       = (state_q == PWB_FILL) && !cmd_start && byte_valid;
    assign commit_now = (state_q == PWB_FILL) && !cmd_start && !byte_valid && commit_req;
    assign commit_ok  = any_valid && !(wp && page_upper);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PWB_IDLE;
            tmr_q   <= '0;
        end else begin
            unique case (state_q)
                PWB_IDLE: begin
                    if (cmd_start) state_q <= PWB_FILL;
                end
                PWB_FILL: begin
                    if (commit_now) begin
                        state_q <= commit_ok ? PWB_WRITE : PWB_IDLE;
                        tmr_q   <= '0;
                    end
                end
                PWB_WRITE: begin
                    if (tmr_q == CNT_W'(HOLD - 1)) begin
                        state_q <= PWB_IDLE;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: state_q <= PWB_IDLE;
            endcase
        end
    end

    assign busy        = (state_q == PWB_WRITE);
    assign scan_active = busy && (tmr_q < CNT_W'(SLOTS));
    assign scan_idx    = tmr_q[IDX_W-1:0];

    AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit_req)); // R5

    AST_EMPTY_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (commit_now && !any_valid) |=> !busy); // R6

    AST_PROTECT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (commit_now && wp && page_upper) |=> !busy); // R7

    AST_BUSY_NOT_CUT: assert property (@(posedge clk) disable iff (rst)
        (busy && tmr_q != CNT_W'(HOLD - 1)) |=> busy); // R8

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int IDX_W       = 4,
    parameter int BUSY_CYCLES = 2_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit_req,
    input  logic              wp,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    output logic              busy,
    output logic [ADDR_W-1:0] addr_cnt
);
    localparam int HI_W = ADDR_W - IDX_W;

    logic             load, step, scan_active, any_valid, rd_valid;
    logic [IDX_W-1:0] scan_idx;
    logic [DATA_W-1:0] rd_data;

    pwb_addr_track #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .clk(clk), .rst(rst), .load(load), .load_addr(cmd_addr),
        .step(step), .addr_q(addr_cnt)
    );

    pwb_slot_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst), .clr(load), .wr_en(step),
        .wr_idx(addr_cnt[IDX_W-1:0]), .wr_data(byte_data),
        .rd_idx(scan_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .any_valid(any_valid)
    );

    pwb_commit_seq #(.IDX_W(IDX_W), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .byte_valid(byte_valid),
        .commit_req(commit_req), .wp(wp), .page_upper(addr_cnt[ADDR_W-1]),
        .any_valid(any_valid), .load(load), .step(step), .busy(busy),
        .scan_active(scan_active), .scan_idx(scan_idx)
    );

    assign arr_we   = scan_active && rd_valid;
    assign arr_addr = {addr_cnt[ADDR_W-1:IDX_W], scan_idx};
    assign arr_data = rd_data;

    AST_WRITE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy); // R4

    AST_COUNTER_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |-> $stable(addr_cnt)); // R9

    AST_WRITE_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> (arr_addr[ADDR_W-1:IDX_W] == $past(arr_addr[ADDR_W-1:IDX_W])
                                       && arr_addr[IDX_W-1:0] > $past(arr_addr[IDX_W-1:0]))); // R4

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = '0;

endmodule

// File: tb/page_write_buffer_bench.sv
module page_write_buffer_bench;
    localparam int BUSY = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_start = 1'b0;
    logic [8:0] cmd_addr = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       commit_req = 1'b0;
    logic       wp = 1'b0;
    logic       arr_we, busy;
    logic [8:0] arr_addr, addr_cnt;
    logic [7:0] arr_data;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_tag = "R4";
    logic [16:0] exp_q [$];

    always #2 clk = ~clk;

    page_write_buffer #(.BUSY_CYCLES(BUSY)) u_page_write_buffer (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .commit_req(commit_req),
        .wp(wp), .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
        .busy(busy), .addr_cnt(addr_cnt)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each array write
    always @(negedge clk) begin
        if (!rst && arr_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, "unexpected array write", {arr_addr, arr_data}, 0);
            end else begin
                logic [16:0] e;
                e = exp_q.pop_front();
                check({arr_addr, arr_data} == e, cur_tag, "array write {addr,data}",
                      {arr_addr, arr_data}, e);
            end
        end
    end

    task automatic send_cmd(input logic [8:0] a);
        @(negedge clk); cmd_start = 1'b1; cmd_addr = a;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk); byte_valid = 1'b1; byte_data = d;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    // driver: runs a write command and pushes the predicted writes
    task automatic run_write(input logic [8:0] a, input int n, input logic [7:0] seed,
                             input logic wpv, input bit raise_wp, input bit disturb,
                             input string tag);
        logic [7:0]  mdat [16];
        logic [15:0] mval;
        logic [3:0]  off;
        bit          exp_busy;
        int          cnt;
        mval = '0;
        off  = a[3:0];
        for (int s = 0; s < 16; s++) mdat[s] = '0;
        cur_tag = tag;
        wp = wpv;
        send_cmd(a);
        for (int i = 0; i < n; i++) begin
            mdat[off] = seed + 8'(i);
            mval[off] = 1'b1;
            send_byte(seed + 8'(i));
            off = off + 4'd1;
        end
        exp_busy = (mval != 0) && !(wpv && a[8]);
        if (exp_busy)
            for (int s = 0; s < 16; s++)
                if (mval[s]) exp_q.push_back({a[8:4], 4'(s), mdat[s]});
        @(negedge clk); commit_req = 1'b1;
        @(negedge clk); commit_req = 1'b0;
        cnt = 0;
        while (busy && cnt < BUSY + 10) begin
            cnt++;
            if (raise_wp && cnt == 2) wp = 1'b1;
            if (disturb && cnt == 3) begin
                cmd_start = 1'b1; cmd_addr = 9'h0AA; byte_valid = 1'b1;
                byte_data = 8'hEE; commit_req = 1'b1;
            end else begin
                cmd_start = 1'b0; byte_valid = 1'b0; commit_req = 1'b0;
            end
            @(negedge clk);
        end
        cmd_start = 1'b0; byte_valid = 1'b0; commit_req = 1'b0;
        check(cnt == (exp_busy ? BUSY : 0), exp_busy ? "R5" : tag, "busy cycle count",
              cnt, exp_busy ? BUSY : 0);
        @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, disturb ? "R9" : tag, "busy after write", busy, 0);
        check(exp_q.size() == 0, tag, "writes left unseen", exp_q.size(), 0);
        exp_q.delete();
        check(addr_cnt == {a[8:4], off}, disturb ? "R9" : "R10", "address counter",
              addr_cnt, {a[8:4], off});
        wp = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(arr_we == 1'b0, "R1", "arr_we after reset", arr_we, 0);
        check(addr_cnt == 9'h000, "R1", "addr_cnt after reset", addr_cnt, 0);

        run_write(9'h023, 1, 8'hA5, 1'b0, 1'b0, 1'b0, "R2");   // single byte
        run_write(9'h05C, 6, 8'h10, 1'b0, 1'b0, 1'b0, "R2");   // wraps inside page
        run_write(9'h0A0, 16, 8'h40, 1'b0, 1'b0, 1'b0, "R10"); // ends on slot 15
        run_write(9'h135, 20, 8'h80, 1'b0, 1'b0, 1'b0, "R3");  // overlong burst, upper half, wp low
        run_write(9'h1F7, 0, 8'h00, 1'b0, 1'b0, 1'b0, "R6");   // address-only write
        run_write(9'h1C0, 3, 8'h30, 1'b1, 1'b0, 1'b0, "R7");   // protected upper half
        run_write(9'h0E2, 2, 8'h55, 1'b1, 1'b0, 1'b0, "R7");   // lower half with wp high
        run_write(9'h180, 2, 8'h66, 1'b0, 1'b1, 1'b0, "R8");   // wp raised mid-write
        run_write(9'h011, 3, 8'h21, 1'b0, 1'b0, 1'b1, "R9");   // strobes during busy

        // R11: bytes for an abandoned command must not be written
        send_cmd(9'h040);
        send_byte(8'hC1);
        send_byte(8'hC2);
        run_write(9'h060, 1, 8'h77, 1'b0, 1'b0, 1'b0, "R11");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule